// File: doc/BRIEF.md
# Watchdog Timer with Write-Protected Control

This block is a watchdog for a system-on-chip. A counter advances once for every tick of a clock-enable input and times out after a programmable interval. Each time-out sets a sticky status flag and can raise an interrupt. When the system sits in power-down, a time-out can also raise a wake-up pulse. If software does not restart the count within a fixed grace window after a time-out, the block can issue a one-cycle reset request to the system reset controller.

Software reaches the block through a small word-addressed register port with three words: control, interrupt enable and status. Control fields accept writes only while an external protection sequence holds the `unlock` input high. Status flags are read-only and are cleared by writing 1 to them. The block also contains a two-flop reset synchronizer, so its asynchronous reset is released in step with the clock.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control word (offset 0x0), the interrupt-enable word (offset 0x4) and the status word (offset 0x8) all read zero, and irq, wake_req and rst_req are low. Any other offset reads zero.
- R2: Writing control bit 0 as 1 while unlocked holds the counter at zero for CLR_HOLD (3) cycles. Bit 0 reads 1 over that span and 0 after it. The next time-out comes CLR_HOLD plus one full interval after the write.
- R3: Control bit 1 enables the reset request, bit 2 enables wake-up, bit 3 enables the timer and bits 6:4 select the interval. All of these read back as written.
- R4: A control write made while `unlock` is low leaves every control field unchanged.
- R5: Clearing the enable bit resets the counter, so after re-enabling, a full interval is counted from zero.
- R6: Status bit 0 is set on every time-out. irq equals interrupt-enable bit 0 AND status bit 0.
- R7: While control bit 1 is clear, status bit 1 never sets and rst_req never rises.
- R8: A time-out with `pd_mode` high and control bit 2 set sets status bits 2 and 0 together and pulses wake_req for one cycle. With bit 2 clear, status bit 2 stays 0.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. The interrupt-enable word is not write-protected.
- R10: With interval select n, a time-out occurs on the 2^(4+2n)-th counter tick after the count starts. Only cycles with tick_en high advance the counter.
- R11: If the reset function is enabled and the counter is not cleared within GRACE (1024) ticks after a time-out, rst_req is high for exactly one cycle, on the 1024th tick, and status bit 1 sets in the same cycle.
- R12: If a hardware set and a write-1 clear hit the same status bit in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter tick enable (engine clock enable) |
| unlock | input | 1 | High while control writes are permitted |
| pd_mode | input | 1 | High while the system is in power-down |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt, level |
| wake_req | output | 1 | One-cycle wake-up pulse |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions check the following on every cycle:
- locked control writes change nothing;
- a time-out always leaves the time-out flag set, even against a clear in the same cycle;
- the reset flag and rst_req only appear with the reset function enabled;
- rst_req never lasts longer than one cycle;
- the wake flag never appears without the time-out flag;
- a disabled counter sits at zero.

The bench scenarios are needed for the exact interval lengths under several tick patterns, the stretch added by a clear, the 1024-tick grace delay and the read-back of every field.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned SEL_W   = 3;
  // word indices of the register map
  localparam int unsigned IDX_CTL = 0;
  localparam int unsigned IDX_IE  = 1;
  localparam int unsigned IDX_STS = 2;
  // control bit positions
  localparam int unsigned B_CLR   = 0;
  localparam int unsigned B_RSTEN = 1;
  localparam int unsigned B_WKEN  = 2;
  localparam int unsigned B_EN    = 3;
  localparam int unsigned B_SEL   = 4;
  // status bit positions
  localparam int unsigned S_TO    = 0;
  localparam int unsigned S_RST   = 1;
  localparam int unsigned S_WAKE  = 2;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             en;
    logic             wk_en;
    logic             rst_en;
  } ctl_t;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/wdog_interval.sv
module wdog_interval #(
  parameter int unsigned BASE  = 4,
  parameter int unsigned STEP  = 2,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             en,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             to_evt
);
  localparam int unsigned CNT_W = BASE + STEP * ((1 << SEL_W) - 1);
  localparam int unsigned SPN_W = $clog2(CNT_W + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] mask;
  logic [SPN_W-1:0] span;

  always_comb begin
    span = SPN_W'(BASE + STEP * int'(sel));
    mask = ~({CNT_W{1'b1}} << span);
    to_evt = en && !clr && tick_en && ((cnt_q & mask) == mask);
  end

  always_comb begin
    if (!en || clr)   cnt_d = '0;
    else if (tick_en) cnt_d = cnt_q + 1'b1;
    else              cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_off_holds_zero_R5: assert property (
    @(posedge clk) disable iff (!rst_n) !en |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_grace.sv
module wdog_grace #(
  parameter int unsigned GRACE = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic en,
  input  logic clr,
  input  logic rst_en,
  input  logic to_evt,
  output logic fire,
  output logic rst_req
);
  localparam int unsigned GR_W = (GRACE > 1) ? $clog2(GRACE) : 1;

  logic            armed_q, armed_d;
  logic [GR_W-1:0] gcnt_q, gcnt_d;
  logic            last;
  logic            rst_req_q;

  always_comb begin
    last    = armed_q && tick_en && (gcnt_q == GR_W'(GRACE - 1));
    fire    = last && rst_en;
    armed_d = armed_q;
    gcnt_d  = gcnt_q;
    if (!en || clr) begin
      armed_d = 1'b0;
      gcnt_d  = '0;
    end else begin
      if (armed_q && tick_en) begin
        if (last) begin
          armed_d = 1'b0;
          gcnt_d  = '0;
        end else begin
          gcnt_d  = gcnt_q + 1'b1;
        end
      end
      if (to_evt && !armed_d) begin
        armed_d = 1'b1;
        gcnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      gcnt_q    <= '0;
      rst_req_q <= 1'b0;
    end else begin
      armed_q   <= armed_d;
      gcnt_q    <= gcnt_d;
      rst_req_q <= fire;
    end
  end

  assign rst_req = rst_req_q;

  assert_req_single_R11: assert property (
    @(posedge clk) disable iff (!rst_n) rst_req |=> !rst_req);
  assert_req_gated_R7: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(rst_req) |-> $past(rst_en));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CLR_HOLD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlock,
  input  logic              pd_mode,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              to_evt,
  input  logic              grace_fire,
  output ctl_t              ctl,
  output logic              clr_active,
  output logic              irq,
  output logic              wake_req
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned CH_W  = $clog2(CLR_HOLD + 1);

  ctl_t            ctl_q, ctl_d;
  logic [CH_W-1:0] clr_q, clr_d;
  logic            ie_q, ie_d;
  logic [2:0]      sts_q, sts_d;
  logic            wake_q, wake_d;

  logic [IDX_W-1:0] idx;
  logic             wr_ctl, wr_ie, wr_sts, ctl_ok;
  logic [2:0]       w1c, hw_set;
  logic             wake_evt;

  assign idx    = bus_addr[ADDR_W-1:2];
  assign wr_ctl = bus_we && (idx == IDX_W'(IDX_CTL));
  assign wr_ie  = bus_we && (idx == IDX_W'(IDX_IE));
  assign wr_sts = bus_we && (idx == IDX_W'(IDX_STS));
  assign ctl_ok = wr_ctl && unlock;

  // control word, write-protected
  always_comb begin
    ctl_d = ctl_q;
    clr_d = clr_q;
    if (clr_q != '0) clr_d = clr_q - 1'b1;
    if (ctl_ok) begin
      ctl_d.sel    = bus_wdata[B_SEL +: SEL_W];
      ctl_d.en     = bus_wdata[B_EN];
      ctl_d.wk_en  = bus_wdata[B_WKEN];
      ctl_d.rst_en = bus_wdata[B_RSTEN];
      if (bus_wdata[B_CLR]) clr_d = CH_W'(CLR_HOLD);
    end
  end

  // interrupt enable, unprotected
  always_comb begin
    ie_d = ie_q;
    if (wr_ie) ie_d = bus_wdata[0];
  end

  // sticky status: hardware set beats software clear
  always_comb begin
    wake_evt = to_evt && pd_mode && ctl_q.wk_en;
    hw_set   = 3'b000;
    hw_set[S_TO]   = to_evt;
    hw_set[S_RST]  = grace_fire;
    hw_set[S_WAKE] = wake_evt;
    w1c    = wr_sts ? bus_wdata[2:0] : 3'b000;
    sts_d  = (sts_q & ~w1c) | hw_set;
    wake_d = wake_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      clr_q  <= '0;
      ie_q   <= 1'b0;
      sts_q  <= 3'b000;
      wake_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      clr_q  <= clr_d;
      ie_q   <= ie_d;
      sts_q  <= sts_d;
      wake_q <= wake_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (idx)
      IDX_W'(IDX_CTL): begin
        bus_rdata[B_CLR]          = (clr_q != '0);
        bus_rdata[B_RSTEN]        = ctl_q.rst_en;
        bus_rdata[B_WKEN]         = ctl_q.wk_en;
        bus_rdata[B_EN]           = ctl_q.en;
        bus_rdata[B_SEL +: SEL_W] = ctl_q.sel;
      end
      IDX_W'(IDX_IE):  bus_rdata[0]   = ie_q;
      IDX_W'(IDX_STS): bus_rdata[2:0] = sts_q;
      default:         bus_rdata      = '0;
    endcase
  end

  assign ctl        = ctl_q;
  assign clr_active = (clr_q != '0);
  assign irq        = ie_q && sts_q[S_TO];
  assign wake_req   = wake_q;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:B_SEL+SEL_W], bus_wdata[DATA_W-1:3]};

  assert_locked_ctl_R4: assert property (
    @(posedge clk) disable iff (!rst_n) (wr_ctl && !unlock) |=> $stable(ctl_q));
  assert_set_wins_R12: assert property (
    @(posedge clk) disable iff (!rst_n) to_evt |=> sts_q[S_TO]);
  assert_rst_flag_gated_R7: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(sts_q[S_RST]) |-> $past(ctl_q.rst_en));
  assert_wake_pairs_R8: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(sts_q[S_WAKE]) |-> sts_q[S_TO]);
  assert_w0_keeps_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
      (wr_sts && !bus_wdata[S_TO] && sts_q[S_TO]) |=> sts_q[S_TO]);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BASE     = 4,
  parameter int unsigned STEP     = 2,
  parameter int unsigned GRACE    = 1024,
  parameter int unsigned CLR_HOLD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              unlock,
  input  logic              pd_mode,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              wake_req,
  output logic              rst_req
);
  logic rst_sync_n;
  ctl_t ctl;
  logic clr_active, to_evt, grace_fire;

  wdog_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdog_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CLR_HOLD (CLR_HOLD)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .unlock     (unlock),
    .pd_mode    (pd_mode),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .to_evt     (to_evt),
    .grace_fire (grace_fire),
    .ctl        (ctl),
    .clr_active (clr_active),
    .irq        (irq),
    .wake_req   (wake_req)
  );

  wdog_interval #(
    .BASE  (BASE),
    .STEP  (STEP),
    .SEL_W (SEL_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_en (tick_en),
    .en      (ctl.en),
    .clr     (clr_active),
    .sel     (ctl.sel),
    .to_evt  (to_evt)
  );

  wdog_grace #(
    .GRACE (GRACE)
  ) u_grace (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_en (tick_en),
    .en      (ctl.en),
    .clr     (clr_active),
    .rst_en  (ctl.rst_en),
    .to_evt  (to_evt),
    .fire    (grace_fire),
    .rst_req (rst_req)
  );
endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic        unlock = 1'b0;
  logic        pd_mode = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wake_req, rst_req;

  int n_chk = 0;
  int n_bad = 0;
  int rst_rises = 0;

  always #5 clk = ~clk;

  wdog_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .unlock(unlock),
    .pd_mode(pd_mode), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .wake_req(wake_req), .rst_req(rst_req)
  );

  always @(posedge clk) if (rst_req) rst_rises++;

  typedef struct packed {
    logic [2:0]  sel;
    logic [1:0]  div;
    logic [11:0] exp;
  } vec_t;
  // interval select, tick spacing, expected edges to time-out
  localparam vec_t VECS [6] = '{
    '{3'd0, 2'd1, 12'd16},
    '{3'd1, 2'd1, 12'd64},
    '{3'd2, 2'd1, 12'd256},
    '{3'd3, 2'd1, 12'd1024},
    '{3'd0, 2'd2, 12'd32},
    '{3'd1, 2'd3, 12'd192}
  };

  localparam logic [3:0] A_CTL = 4'h0, A_IE = 4'h4, A_STS = 4'h8;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic unl);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; unlock = unl;
    @(negedge clk);
    bus_we = 1'b0; unlock = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // counts edges until status bit 0 sets; tick_en high on every div-th edge
  task automatic count_to(input int div, input int lim, output int k);
    logic [31:0] s;
    k = 0;
    bus_addr = A_STS;
    forever begin
      tick_en = ((k + 1) % div) == 0;
      @(negedge clk);
      k++;
      #1;
      s = bus_rdata;
      if (s[0] || k >= lim) break;
    end
    tick_en = 1'b1;
  endtask

  task automatic quiesce();
    wr(A_CTL, 32'h0, 1'b1);
    wr(A_STS, 32'h7, 1'b0);
    wr(A_IE, 32'h0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_CTL, r); check("R1 ctl", r, 0);
    rd(A_IE, r);  check("R1 ie", r, 0);
    rd(A_STS, r); check("R1 sts", r, 0);
    check("R1 outputs", {29'd0, irq, wake_req, rst_req}, 0);
    rd(4'hC, r);  check("R1 unmapped", r, 0);

    // R3 field read-back
    wr(A_CTL, 32'h76, 1'b1);
    rd(A_CTL, r); check("R3 readback", r, 32'h76);
    // R4 locked write ignored
    wr(A_CTL, 32'h0A, 1'b0);
    rd(A_CTL, r); check("R4 locked", r, 32'h76);
    quiesce();

    // R10 interval table
    foreach (VECS[i]) begin
      quiesce();
      wr(A_CTL, {25'd0, VECS[i].sel, 4'b1000}, 1'b1);
      count_to(int'(VECS[i].div), 4000, k);
      check($sformatf("R10 sel%0d div%0d", VECS[i].sel, VECS[i].div), k, VECS[i].exp);
    end
    quiesce();

    // R6 status sets without ie, irq gated
    wr(A_CTL, 32'h08, 1'b1);
    count_to(1, 100, k);
    check("R6 irq off", irq, 0);
    wr(A_IE, 32'h1, 1'b0);
    #1; check("R6 irq on", irq, 1);
    // R9 write 0 keeps, write 1 clears
    wr(A_STS, 32'h0, 1'b0);
    rd(A_STS, r); check("R9 w0 keeps", r[0], 1);
    wr(A_STS, 32'h1, 1'b0);
    rd(A_STS, r); check("R9 w1 clears", r[0], 0);
    check("R6 irq drops", irq, 0);
    quiesce();

    // R5 disabling resets the counter
    wr(A_CTL, 32'h08, 1'b1);
    repeat (10) @(negedge clk);
    wr(A_CTL, 32'h00, 1'b1);
    wr(A_CTL, 32'h08, 1'b1);
    count_to(1, 100, k);
    check("R5 restart", k, 16);
    quiesce();

    // R2 clear bit stretches and self-clears
    wr(A_CTL, 32'h08, 1'b1);
    repeat (10) @(negedge clk);
    wr(A_CTL, 32'h09, 1'b1);
    rd(A_CTL, r); check("R2 clr reads 1", r[0], 1);
    count_to(1, 100, k);
    check("R2 delay", k, 19);
    rd(A_CTL, r); check("R2 clr self", r, 32'h08);
    quiesce();

    // R12 set wins over same-cycle clear
    wr(A_CTL, 32'h08, 1'b1);
    repeat (14) @(negedge clk);
    wr(A_STS, 32'h1, 1'b0);
    rd(A_STS, r); check("R12 set wins", r[0], 1);
    quiesce();

    // R8 wake from power-down
    pd_mode = 1'b1;
    wr(A_CTL, 32'h0C, 1'b1);
    count_to(1, 100, k);
    rd(A_STS, r); check("R8 wake flags", r[2:0], 3'b101);
    check("R8 wake pulse", wake_req, 1);
    @(negedge clk); #1;
    check("R8 pulse ends", wake_req, 0);
    quiesce();
    wr(A_CTL, 32'h08, 1'b1);
    count_to(1, 100, k);
    rd(A_STS, r); check("R8 no wake en", r[2:0], 3'b001);
    pd_mode = 1'b0;
    quiesce();

    // R7 no reset while disabled
    rst_rises = 0;
    wr(A_CTL, 32'h08, 1'b1);
    repeat (1100) @(negedge clk);
    rd(A_STS, r); check("R7 flag stays", r[1], 0);
    check("R7 no req", rst_rises, 0);
    quiesce();

    // R11 grace reset
    wr(A_CTL, 32'h0A, 1'b1);
    k = 0;
    forever begin
      @(negedge clk); k++; #1;
      if (rst_req || k >= 3000) break;
    end
    check("R11 delay", k, 1040);
    rd(A_STS, r); check("R11 flag", r[1], 1);
    @(negedge clk); #1;
    check("R11 one cycle", rst_req, 0);
    quiesce();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule